// File: doc/BRIEF.md
# Debug Emulator Mode Controller

This block keeps the flag that says a processor core is running its debug emulator mode. Three exception points can set the flag. The first is the start of reset exception processing, when a software-writable force bit is set and the external reset input has been released. The second is the start of any debug-interrupt exception. The third is the start of a trace exception, when the trace control bit is set. A completed return-from-exception clears the flag.

While the flag is set, and in the cycle that sets it, the block blocks every incoming interrupt level, level 7 included. When the mapping bit is set it also rewrites the attributes of each bus access into a reserved debug space and withholds permission to use the cache and the on-chip SRAM. This covers the stack-frame writes and the vector fetch of the exception that caused entry.

A 4-bit status code marks the single entry cycle and the single exit cycle. An armed breakpoint condition, modelled only as a level input, asks for a fresh debug interrupt in two cases: when it rises outside the mode, and when it is still armed at the moment the mode is left.

Top module: `emu_mode_ctrl`

## Requirements
- R1: After synchronous reset the mode flag reads 0, the status code reads 0x0 and the debug-interrupt request reads 0.
- R2: A reset-exception start strobe with the force bit set and the external reset input released sets the flag on the next edge. The strobe does nothing while the external reset is asserted or while the force bit is clear.
- R3: A debug-interrupt start strobe always sets the flag on the next edge.
- R4: A trace start strobe sets the flag only while the trace control bit is 1. With the bit at 0 it does nothing.
- R5: Entry causes that arrive together give one entry cycle with status 0xD. A cause that arrives while the flag is already set gives no second 0xD.
- R6: While the flag is set, and in the entry cycle, the interrupt level output is 0 for every input level from 0 to 7. Otherwise it equals the input level.
- R7: A return-from-exception strobe while the flag is set gives status 0x7 in that cycle and clears the flag on the next edge. Outside the mode the strobe has no effect.
- R8: Outside entry and exit cycles the status output is 0x0.
- R9: In the mode, or in its entry cycle, with the mapping bit at 1, the transfer type is forced to 0x2. The transfer modifier becomes 0x5 for data accesses and 0x6 for instruction fetches. The cache-allow and SRAM-allow outputs are 0.
- R10: Outside the mode, or with the mapping bit at 0, the transfer type and modifier pass through unchanged and both allow outputs are 1.
- R11: If the breakpoint input is 1 in an exit cycle, the debug-interrupt request is 1 for exactly the following cycle. The same holds when the breakpoint input rises while the flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst_act | input | 1 | External reset input still asserted |
| rst_exc_go | input | 1 | Reset exception processing begins |
| force_emu | input | 1 | Force-emulate control bit |
| dbg_exc_go | input | 1 | Debug-interrupt exception processing begins |
| trc_exc_go | input | 1 | Trace exception processing begins |
| trc_en | input | 1 | Trace control bit |
| rte_done | input | 1 | Return-from-exception completes |
| bkpt_armed | input | 1 | Breakpoint condition armed |
| map_en | input | 1 | Mapping control bit |
| irq_lvl_in | input | 3 | Requested interrupt level |
| irq_lvl_out | output | 3 | Interrupt level passed to the core |
| acc_fetch | input | 1 | Current access is an instruction fetch |
| acc_tt_in | input | 2 | Transfer type from the core |
| acc_tm_in | input | 3 | Transfer modifier from the core |
| acc_tt_out | output | 2 | Transfer type to the bus |
| acc_tm_out | output | 3 | Transfer modifier to the bus |
| cache_ok | output | 1 | Cache use permitted |
| sram_ok | output | 1 | On-chip SRAM use permitted |
| pst_code | output | 4 | Processor status code |
| emu_flag | output | 1 | Registered mode flag |
| dbg_irq_req | output | 1 | Request for a new debug interrupt |

## Verification
The bench builds the block with its default parameters: remapping generated in, a 2-bit transfer type, a 3-bit modifier and a 3-bit interrupt level. These widths let every interrupt level from 0 to 7 and both remapped modifiers, 0x5 and 0x6, be driven and observed. The active remapping variant puts the entry-cycle rewrite and the pass-through for a clear mapping bit within reach of the bench. The pass-through variant, selected with the remapping parameter at 0, is covered only by elaboration.

// File: rtl/emu_pkg.sv
package emu_pkg;
   localparam int NCAUSE = 3;
   localparam int PST_W  = 4;
   localparam logic [PST_W-1:0] PST_IDLE  = 4'h0;
   localparam logic [PST_W-1:0] PST_ENTER = 4'hD;
   localparam logic [PST_W-1:0] PST_EXIT  = 4'h7;
   localparam logic [1:0] TT_DEBUG   = 2'h2;
   localparam logic [2:0] TM_DBG_DAT = 3'h5;
   localparam logic [2:0] TM_DBG_INS = 3'h6;
   typedef enum logic [1:0] {C_RESET = 2'd0, C_DEBUG = 2'd1, C_TRACE = 2'd2} cause_e;
endpackage

// File: rtl/emu_entry_det.sv
module emu_entry_det
   import emu_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic ext_rst_act,
   input  logic rst_exc_go,
   input  logic force_emu,
   input  logic dbg_exc_go,
   input  logic trc_exc_go,
   input  logic trc_en,
   input  logic rte_done,
   input  logic bkpt_armed,
   output logic emu_q,
   output logic enter,
   output logic leave,
   output logic dbg_req
);
   logic [NCAUSE-1:0] cause;
   logic bkpt_prev;

   for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
      if (i == int'(C_RESET)) begin : g_rst
         assign cause[i] = rst_exc_go & force_emu & ~ext_rst_act;
      end else if (i == int'(C_DEBUG)) begin : g_dbg
         assign cause[i] = dbg_exc_go;
      end else begin : g_trc
         assign cause[i] = trc_exc_go & trc_en;
      end
   end

   assign enter = ~emu_q & (|cause);
   assign leave = emu_q & rte_done;

   always_ff @(posedge clk) begin
      if (rst) begin
         emu_q     <= 1'b0;
         bkpt_prev <= 1'b0;
         dbg_req   <= 1'b0;
      end else begin
         if (enter) emu_q <= 1'b1;
         else if (leave) emu_q <= 1'b0;
         bkpt_prev <= bkpt_armed;
         dbg_req   <= bkpt_armed & (leave | (~emu_q & ~bkpt_prev));
      end
   end

   // R3: a debug strobe outside the mode always sets the flag
   a_r3_debug_enters: assert property (@(posedge clk) disable iff (rst)
      (dbg_exc_go && !emu_q) |=> emu_q);
   // R7: exit clears the flag
   a_r7_exit_clears: assert property (@(posedge clk) disable iff (rst)
      leave |=> !emu_q);
   // R11: armed breakpoint at exit raises a request
   a_r11_rebreak: assert property (@(posedge clk) disable iff (rst)
      (leave && bkpt_armed) |=> dbg_req);
   // R2: no entry from reset cause while external reset held
   a_r2_hold_in_reset: assert property (@(posedge clk) disable iff (rst)
      (!emu_q && ext_rst_act && !dbg_exc_go && !(trc_exc_go && trc_en)) |=> !emu_q);
endmodule

// File: rtl/emu_pst_enc.sv
module emu_pst_enc
   import emu_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             enter,
   input  logic             leave,
   output logic [PST_W-1:0] pst
);
   always_comb begin
      if (enter)      pst = PST_ENTER;
      else if (leave) pst = PST_EXIT;
      else            pst = PST_IDLE;
   end

   // R5: two consecutive entry codes never occur
   a_r5_single_enter: assert property (@(posedge clk) disable iff (rst)
      (pst == PST_ENTER) |=> (pst != PST_ENTER));
   // R8: entry and exit are never signalled together
   a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(enter && leave));
endmodule

// File: rtl/emu_bus_remap.sv
module emu_bus_remap
   import emu_pkg::*;
#(
   parameter int  TT_W    = 2,
   parameter int  TM_W    = 3,
   parameter bit  HAS_MAP = 1'b1
)(
   input  logic            clk,
   input  logic            rst,
   input  logic            emu_on,
   input  logic            map_en,
   input  logic            acc_fetch,
   input  logic [TT_W-1:0] tt_in,
   input  logic [TM_W-1:0] tm_in,
   output logic [TT_W-1:0] tt_out,
   output logic [TM_W-1:0] tm_out,
   output logic            cache_ok,
   output logic            sram_ok
);
   if (TT_W < 2) begin : g_chk_tt
      $error("emu_bus_remap: TT_W must be at least 2");
   end
   if (TM_W < 3) begin : g_chk_tm
      $error("emu_bus_remap: TM_W must be at least 3");
   end

   if (HAS_MAP) begin : g_map
      logic remap;
      assign remap    = emu_on & map_en;
      assign tt_out   = remap ? TT_W'(TT_DEBUG) : tt_in;
      assign tm_out   = remap ? (acc_fetch ? TM_W'(TM_DBG_INS) : TM_W'(TM_DBG_DAT)) : tm_in;
      assign cache_ok = ~remap;
      assign sram_ok  = ~remap;

      // R9: a mapped access never reaches cache or SRAM and carries debug type
      a_r9_no_cache: assert property (@(posedge clk) disable iff (rst)
         (emu_on && map_en) |-> (!cache_ok && !sram_ok && tt_out == TT_W'(TT_DEBUG)));
      // R10: without the mode attributes are untouched
      a_r10_pass: assert property (@(posedge clk) disable iff (rst)
         !emu_on |-> (tt_out == tt_in && tm_out == tm_in));
   end else begin : g_pass
      assign tt_out   = tt_in;
      assign tm_out   = tm_in;
      assign cache_ok = 1'b1;
      assign sram_ok  = 1'b1;
   end
endmodule

// File: rtl/emu_mode_ctrl.sv
module emu_mode_ctrl
   import emu_pkg::*;
#(
   parameter int TT_W    = 2,
   parameter int TM_W    = 3,
   parameter int IRQ_W   = 3,
   parameter bit HAS_MAP = 1'b1
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             ext_rst_act,
   input  logic             rst_exc_go,
   input  logic             force_emu,
   input  logic             dbg_exc_go,
   input  logic             trc_exc_go,
   input  logic             trc_en,
   input  logic             rte_done,
   input  logic             bkpt_armed,
   input  logic             map_en,
   input  logic [IRQ_W-1:0] irq_lvl_in,
   output logic [IRQ_W-1:0] irq_lvl_out,
   input  logic             acc_fetch,
   input  logic [TT_W-1:0]  acc_tt_in,
   input  logic [TM_W-1:0]  acc_tm_in,
   output logic [TT_W-1:0]  acc_tt_out,
   output logic [TM_W-1:0]  acc_tm_out,
   output logic             cache_ok,
   output logic             sram_ok,
   output logic [PST_W-1:0] pst_code,
   output logic             emu_flag,
   output logic             dbg_irq_req
);
   if (IRQ_W < 1) begin : g_chk_irq
      $error("emu_mode_ctrl: IRQ_W must be positive");
   end

   logic emu_q, enter, leave, emu_on;

   emu_entry_det u_det (
      .clk(clk), .rst(rst), .ext_rst_act(ext_rst_act), .rst_exc_go(rst_exc_go),
      .force_emu(force_emu), .dbg_exc_go(dbg_exc_go), .trc_exc_go(trc_exc_go),
      .trc_en(trc_en), .rte_done(rte_done), .bkpt_armed(bkpt_armed),
      .emu_q(emu_q), .enter(enter), .leave(leave), .dbg_req(dbg_irq_req)
   );

   emu_pst_enc u_pst (
      .clk(clk), .rst(rst), .enter(enter), .leave(leave), .pst(pst_code)
   );

   assign emu_on = emu_q | enter;

   emu_bus_remap #(.TT_W(TT_W), .TM_W(TM_W), .HAS_MAP(HAS_MAP)) u_map (
      .clk(clk), .rst(rst), .emu_on(emu_on), .map_en(map_en), .acc_fetch(acc_fetch),
      .tt_in(acc_tt_in), .tm_in(acc_tm_in), .tt_out(acc_tt_out), .tm_out(acc_tm_out),
      .cache_ok(cache_ok), .sram_ok(sram_ok)
   );

   assign irq_lvl_out = emu_on ? '0 : irq_lvl_in;
   assign emu_flag    = emu_q;

   // R6: no interrupt level reaches the core while the flag is set
   a_r6_mask: assert property (@(posedge clk) disable iff (rst)
      emu_flag |-> (irq_lvl_out == '0));
   // R5: entry code only when the flag was clear
   a_r5_enter_from_idle: assert property (@(posedge clk) disable iff (rst)
      (pst_code == PST_ENTER) |-> !emu_flag);
   // R7: exit code only from inside the mode, flag drops next
   a_r7_exit_code: assert property (@(posedge clk) disable iff (rst)
      (pst_code == PST_EXIT) |=> !emu_flag);
endmodule

// File: tb/tb_emu_mode_ctrl.sv
module tb_emu_mode_ctrl;
   logic clk = 1'b0;
   logic rst;
   logic ext_rst_act, rst_exc_go, force_emu, dbg_exc_go, trc_exc_go, trc_en;
   logic rte_done, bkpt_armed, map_en, acc_fetch;
   logic [2:0] irq_lvl_in, irq_lvl_out;
   logic [1:0] acc_tt_in, acc_tt_out;
   logic [2:0] acc_tm_in, acc_tm_out;
   logic cache_ok, sram_ok, emu_flag, dbg_irq_req;
   logic [3:0] pst_code;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   emu_mode_ctrl dut (
      .clk(clk), .rst(rst), .ext_rst_act(ext_rst_act), .rst_exc_go(rst_exc_go),
      .force_emu(force_emu), .dbg_exc_go(dbg_exc_go), .trc_exc_go(trc_exc_go),
      .trc_en(trc_en), .rte_done(rte_done), .bkpt_armed(bkpt_armed), .map_en(map_en),
      .irq_lvl_in(irq_lvl_in), .irq_lvl_out(irq_lvl_out), .acc_fetch(acc_fetch),
      .acc_tt_in(acc_tt_in), .acc_tm_in(acc_tm_in), .acc_tt_out(acc_tt_out),
      .acc_tm_out(acc_tm_out), .cache_ok(cache_ok), .sram_ok(sram_ok),
      .pst_code(pst_code), .emu_flag(emu_flag), .dbg_irq_req(dbg_irq_req)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic strobes_off();
      rst_exc_go = 0; dbg_exc_go = 0; trc_exc_go = 0; rte_done = 0;
   endtask

   // advance to the next negedge: one posedge has passed, inputs stay stable
   task automatic tick();
      @(negedge clk);
   endtask

   task automatic leave_mode();
      rte_done = 1; #1;
      chk("R7 exit code", pst_code, 4'h7);
      tick(); strobes_off(); #1;
      chk("R7 flag cleared", emu_flag, 0);
   endtask

   task automatic t_reset();
      rst = 1; tick(); tick(); rst = 0; #1;
      chk("R1 flag", emu_flag, 0);
      chk("R1 pst", pst_code, 0);
      chk("R1 req", dbg_irq_req, 0);
      irq_lvl_in = 3'd5; #1;
      chk("R6 pass level", irq_lvl_out, 5);
   endtask

   task automatic t_reset_entry();
      ext_rst_act = 1; force_emu = 1; rst_exc_go = 1; #1;
      chk("R2 held reset pst", pst_code, 0);
      tick(); #1;
      chk("R2 held reset flag", emu_flag, 0);
      ext_rst_act = 0; force_emu = 0; #1;
      chk("R2 force clear pst", pst_code, 0);
      tick(); #1;
      chk("R2 force clear flag", emu_flag, 0);
      force_emu = 1; #1;
      chk("R2 entry pst", pst_code, 4'hD);
      tick(); strobes_off(); force_emu = 0; #1;
      chk("R2 flag set", emu_flag, 1);
      chk("R8 idle in mode", pst_code, 0);
      leave_mode();
   endtask

   task automatic t_debug();
      dbg_exc_go = 1; irq_lvl_in = 3'd7; #1;
      chk("R3 entry pst", pst_code, 4'hD);
      chk("R6 entry cycle mask", irq_lvl_out, 0);
      tick(); #1;
      chk("R3 flag set", emu_flag, 1);
      chk("R5 no second entry", pst_code, 0);
      chk("R6 level 7 masked", irq_lvl_out, 0);
      strobes_off(); irq_lvl_in = 3'd3; #1;
      chk("R6 level 3 masked", irq_lvl_out, 0);
      leave_mode();
      chk("R6 unmasked after exit", irq_lvl_out, 3);
      rte_done = 1; #1;
      chk("R7 rte outside ignored", pst_code, 0);
      tick(); rte_done = 0; #1;
      chk("R7 rte outside flag", emu_flag, 0);
   endtask

   task automatic t_trace();
      trc_en = 0; trc_exc_go = 1; #1;
      chk("R4 disabled pst", pst_code, 0);
      tick(); #1;
      chk("R4 disabled flag", emu_flag, 0);
      trc_en = 1; #1;
      chk("R4 enabled pst", pst_code, 4'hD);
      tick(); strobes_off(); trc_en = 0; #1;
      chk("R4 flag set", emu_flag, 1);
      leave_mode();
   endtask

   task automatic t_simul();
      force_emu = 1; trc_en = 1;
      rst_exc_go = 1; dbg_exc_go = 1; trc_exc_go = 1; #1;
      chk("R5 joint entry pst", pst_code, 4'hD);
      tick(); #1;
      chk("R5 one entry only", pst_code, 0);
      chk("R5 flag", emu_flag, 1);
      strobes_off(); force_emu = 0; trc_en = 0;
      leave_mode();
   endtask

   task automatic t_map();
      map_en = 1; acc_fetch = 1; acc_tt_in = 2'd0; acc_tm_in = 3'd1; #1;
      chk("R10 tt pass", acc_tt_out, 0);
      chk("R10 tm pass", acc_tm_out, 1);
      chk("R10 cache ok", cache_ok, 1);
      dbg_exc_go = 1; #1;
      chk("R9 entry fetch tt", acc_tt_out, 2);
      chk("R9 entry fetch tm", acc_tm_out, 6);
      chk("R9 cache off", cache_ok, 0);
      chk("R9 sram off", sram_ok, 0);
      tick(); strobes_off(); acc_fetch = 0; acc_tt_in = 2'd3; acc_tm_in = 3'd2; #1;
      chk("R9 data tm", acc_tm_out, 5);
      chk("R9 data tt", acc_tt_out, 2);
      map_en = 0; #1;
      chk("R10 map off tt", acc_tt_out, 3);
      chk("R10 map off tm", acc_tm_out, 2);
      chk("R10 map off sram", sram_ok, 1);
      map_en = 1;
      leave_mode();
      chk("R10 after exit tm", acc_tm_out, 2);
      map_en = 0;
   endtask

   task automatic t_bkpt();
      dbg_exc_go = 1; tick(); strobes_off();
      bkpt_armed = 1; tick(); #1;
      chk("R11 no request in mode", dbg_irq_req, 0);
      rte_done = 1; tick(); strobes_off(); #1;
      chk("R11 request after exit", dbg_irq_req, 1);
      tick(); #1;
      chk("R11 single pulse", dbg_irq_req, 0);
      bkpt_armed = 0; tick();
      dbg_exc_go = 1; tick(); strobes_off();
      rte_done = 1; tick(); strobes_off(); #1;
      chk("R11 no request unarmed", dbg_irq_req, 0);
      bkpt_armed = 1; tick(); #1;
      chk("R11 request on new hit", dbg_irq_req, 1);
      bkpt_armed = 0; tick(); #1;
      chk("R11 new hit pulse ends", dbg_irq_req, 0);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got 0x0 expected 0x1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst = 1; ext_rst_act = 0; force_emu = 0; trc_en = 0; bkpt_armed = 0;
      map_en = 0; acc_fetch = 0; acc_tt_in = 0; acc_tm_in = 0; irq_lvl_in = 0;
      strobes_off();
      @(negedge clk);
      t_reset();
      t_reset_entry();
      t_debug();
      t_trace();
      t_simul();
      t_map();
      t_bkpt();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule